// File: doc/BRIEF.md
# Infrared Carrier Keying Stage

This block turns a serial bit stream into an infrared LED drive signal by keying externally generated carrier waveforms. Two square-wave carriers arrive from a pair of timers. In on/off keying (ASK) the bit either passes carrier A or forces the output idle. In frequency keying (FSK) the bit picks carrier A or carrier B. The keying bit is taken either from a UART transmit line or from a bit held in the block's configuration word. A polarity bit can invert the keyed result to suit how the LED driver is wired.

The configuration word has five bits. It is loaded on a rising clock edge while the write strobe is high. When the enable bit is clear, the output pin simply repeats the UART transmit line, so a plain serial link keeps working. The path from the carriers, the UART line and the stored configuration to the pin has no register in it. This block does not generate the carriers. It has no streaming data interface, so valid/ready handshaking does not apply and every pin is a plain level signal.

Top module: `ir_mod_top`

## Requirements
- R1: While the enable bit (cfg_wdata bit 0 as stored) is 0, ir_pin equals uart_tx, whatever the other configuration bits and the carriers are doing.
- R2: When enabled with the mode bit (bit 2) at 0 (ASK), the keyed value is carrier_a while the data bit is 1 and 0 while the data bit is 0.
- R3: When enabled with the mode bit at 1 (FSK), the keyed value is carrier_a while the data bit is 1 and carrier_b while the data bit is 0.
- R4: The source-select bit (bit 3) picks the data bit: 0 takes uart_tx, 1 takes the stored software data bit (bit 4).
- R5: When enabled, the invert bit (bit 1) set to 1 makes ir_pin the complement of the keyed value. When it is 0, ir_pin is the keyed value itself.
- R6: ir_pin follows changes on carrier_a, carrier_b and uart_tx within the same cycle, without waiting for a clock edge.
- R7: After asynchronous reset (rst_n low) all configuration bits are 0, so ir_pin follows uart_tx.
- R8: On a rising edge of clk with cfg_we high, the configuration takes the value of cfg_wdata. With cfg_we low, the configuration keeps its value whatever cfg_wdata holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | New configuration: bit0 enable, bit1 invert, bit2 FSK mode, bit3 software source, bit4 software data |
| carrier_a | input | 1 | First timer carrier (used for data 1 and for ASK) |
| carrier_b | input | 1 | Second timer carrier (used for FSK data 0) |
| uart_tx | input | 1 | UART transmit line |
| ir_pin | output | 1 | Drive signal for the infrared emitter |

## Verification
Every one of the 32 configuration words is applied. Under each word, all eight combinations of the two carriers and the UART line are driven. This separates the bypass path, gating in ASK, carrier choice in FSK, the data source and the inversion, because every term shows up as a different pin value. The inputs are changed a second time between clock edges to show that the path has no register. Writes with the strobe low, using changing data words, show that the stored setting holds. A random run then mixes writes and input changes and compares the pin on every clock.

// File: rtl/ir_mod_pkg.sv
package ir_mod_pkg;
  // bit 0 is the enable, bit 4 the software data bit
  typedef struct packed {
    logic sw_bit;
    logic sw_sel;
    logic fsk;
    logic inv;
    logic en;
  } ir_cfg_t;

  localparam int unsigned IR_CFG_W = $bits(ir_cfg_t);
endpackage

// File: rtl/ir_cfg_reg.sv
module ir_cfg_reg
  import ir_mod_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [IR_CFG_W-1:0] wdata,
  output ir_cfg_t             cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= ir_cfg_t'(wdata);
  end

  // R8: a write lands on the next edge
  a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg_q == ir_cfg_t'($past(wdata))));
  // R8: no strobe, no change
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg_q));
endmodule

// File: rtl/ir_data_sel.sv
module ir_data_sel (
  input  logic sw_sel,
  input  logic sw_bit,
  input  logic uart_tx,
  output logic data_bit
);
  always_comb data_bit = sw_sel ? sw_bit : uart_tx;
endmodule

// File: rtl/ir_key_mux.sv
module ir_key_mux (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fsk,
  input  logic inv,
  input  logic data_bit,
  input  logic carrier_a,
  input  logic carrier_b,
  input  logic uart_tx,
  output logic pin
);
  logic keyed;

  always_comb begin
    if (fsk) keyed = data_bit ? carrier_a : carrier_b;
    else     keyed = data_bit & carrier_a;
    pin = en ? (keyed ^ inv) : uart_tx;
  end

  // R1: bypass while disabled
  a_r1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (pin == uart_tx));
  // R2: ASK with data 0 leaves only the polarity level
  a_r2_ask_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !fsk && !data_bit) |-> (pin == inv));
  // R3: FSK with data 0 uses the second carrier
  a_r3_fsk_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fsk && !data_bit) |-> (pin == (carrier_b ^ inv)));
  // R2, R3: data 1 always carries carrier A
  a_r3_data_one: assert property (@(posedge clk) disable iff (!rst_n)
    (en && data_bit) |-> (pin == (carrier_a ^ inv)));
endmodule

// File: rtl/ir_mod_top.sv
module ir_mod_top
  import ir_mod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [4:0] cfg_wdata,
  input  logic       carrier_a,
  input  logic       carrier_b,
  input  logic       uart_tx,
  output logic       ir_pin
);
  ir_cfg_t cfg;
  logic    data_bit;

  ir_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg_q (cfg)
  );

  ir_data_sel u_sel (
    .sw_sel   (cfg.sw_sel),
    .sw_bit   (cfg.sw_bit),
    .uart_tx  (uart_tx),
    .data_bit (data_bit)
  );

  ir_key_mux u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg.en),
    .fsk       (cfg.fsk),
    .inv       (cfg.inv),
    .data_bit  (data_bit),
    .carrier_a (carrier_a),
    .carrier_b (carrier_b),
    .uart_tx   (uart_tx),
    .pin       (ir_pin)
  );

  // R4: with the software source chosen and enabled, the UART line has no say in ASK data-1 gating
  a_r4_sw_source: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && cfg.sw_sel && cfg.sw_bit) |-> (ir_pin == (carrier_a ^ cfg.inv)));
endmodule

// File: tb/sim_ir_mod_top.sv
module sim_ir_mod_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic       carrier_a = 1'b0;
  logic       carrier_b = 1'b0;
  logic       uart_tx = 1'b1;
  logic       ir_pin;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ir_mod_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .carrier_a(carrier_a), .carrier_b(carrier_b), .uart_tx(uart_tx),
    .ir_pin(ir_pin)
  );

  // behavioural reference: stored word as an integer
  int m_cfg = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)      m_cfg <= 0;
    else if (cfg_we) m_cfg <= int'(cfg_wdata);
  end

  function automatic logic expect_pin();
    int  c = m_cfg;
    bit  d;
    bit  k;
    if ((c & 1) == 0) return uart_tx;
    d = ((c & 8) != 0) ? ((c & 16) != 0) : uart_tx;
    if ((c & 4) != 0) k = d ? carrier_a : carrier_b;
    else              k = d ? carrier_a : 1'b0;
    return ((c & 2) != 0) ? ~k : k;
  endfunction

  function automatic string req_tag();
    int c = m_cfg;
    if ((c & 1) == 0) return "R1";
    return {((c & 4) != 0) ? "R3" : "R2", ((c & 8) != 0) ? "/R4" : "", ((c & 2) != 0) ? "/R5" : ""};
  endfunction

  task automatic check(input string ctx);
    logic e = expect_pin();
    n_checks++;
    if (ir_pin !== e) begin
      n_fail++;
      $display("FAIL %s %s cfg=%0d got %b expected %b", req_tag(), ctx, m_cfg, ir_pin, e);
    end
  endtask

  task automatic write_cfg(input int v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = 5'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R7: in reset, with write strobe active, the pin still follows UART
    cfg_we = 1'b1;
    cfg_wdata = 5'h1f;
    repeat (2) @(posedge clk);
    @(negedge clk);
    uart_tx = 1'b0; #1 check("R7 reset low");
    uart_tx = 1'b1; #1 check("R7 reset high");
    cfg_we = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    uart_tx = 1'b0; carrier_a = 1'b1; #1 check("R7 after reset");

    // all words, all input combinations, second change mid-cycle (R6)
    for (int c = 0; c < 32; c++) begin
      write_cfg(c);
      for (int p = 0; p < 8; p++) begin
        @(negedge clk);
        {carrier_a, carrier_b, uart_tx} = 3'(p);
        #1 check("sweep");
        {carrier_a, carrier_b, uart_tx} = 3'(7 - p);
        #1 check("R6 mid-cycle");
      end
    end

    // R8: strobe low, data moving: configuration must hold (FSK, inverted, software 1)
    write_cfg(5'b11111);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      cfg_wdata = 5'(i);
      {carrier_a, carrier_b, uart_tx} = 3'(i);
      #1 check("R8 hold");
    end

    // R4: software data 0 in ASK, UART high must not key the carrier
    write_cfg(5'b01001);
    @(negedge clk);
    uart_tx = 1'b1; carrier_a = 1'b1;
    #1 check("R4 sw zero");

    // random mix, compared every clock
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cfg_we = ($urandom_range(0, 3) == 0);
      cfg_wdata = 5'($urandom);
      carrier_a = 1'($urandom);
      carrier_b = 1'($urandom);
      uart_tx = 1'($urandom);
      #1 check("R8 random");
    end
    cfg_we = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule